// File: doc/BRIEF.md
# Flash Programming Sequencer

This block is the host-side engine that drives the programming pins of a microcontroller's on-chip code flash. From a single start request it walks one of three flows: writing a range of bytes with read-back and retry, erasing the whole chip, or setting one lock bit. It produces the command strobe, the program strobe, the read enable, the address and data buses and a high-voltage select line. When a flow ends it raises either a done flag or an error flag.

Every flow first reads the device's voltage signature. Each later step is a command byte or a program pulse, framed by setup and hold windows that are counted in system clocks. Pulse widths, setup and hold, retry limits and the address width are parameters. The byte data comes from a source port indexed by the address the engine is presenting. Chip erase first writes every byte in the range to 00H. It then sets all three lock bits, then erases, and reads the range back, retrying until every byte reads FFH or the attempt limit is reached.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, and while idle, `cmd_n`, `prog_n` and `oe_n` are high, `tgt_dout_en`, `hv_sel`, `busy`, `done` and `err` are low.
- R2: Every command is a `cmd_n` low pulse of exactly CMD_W clocks. `tgt_dout` carries the command code with `tgt_dout_en` high, stable for at least SU clocks before the falling edge and at least SU clocks after the rising edge. Bus values are likewise stable for SU clocks around every `prog_n` edge.
- R3: Each accepted flow begins with command 90H, then a read (`oe_n` low) at address 032H. `hv_sel` is high during every program pulse of that flow if the byte read was AAH, and low otherwise. `tgt_dout_en` is never high while `oe_n` is low.
- R4: Flow 0 (program) handles each address from `addr_lo` up to `addr_hi` in turn. It issues 40H, then a `prog_n` low pulse of PGM_W clocks with the address and `src_data` on the buses. It then issues C0H and reads the byte back. A match moves on to the next address; after `addr_hi`, `done` is raised.
- R5: A byte that still mismatches after MAX_PGM (10) program pulses stops the flow with `err` high and `done` low, and later addresses are left untouched. A byte that matches on its 10th pulse counts as a success.
- R6: Flow 1 (erase) first programs every address in the range to 00H, using the same pulse, verify and retry rule as R4/R5. It then sets lock bits 1, 2 and 3 (LOCK_N pulses each, as in R8) before the first erase pulse.
- R7: Each erase attempt issues 20H, then D0H. It then drives a `prog_n` pulse of ERS_W clocks with D0H held on the bus, issues A0H, and reads each address in the range expecting FFH. A mismatch starts a new attempt. After MAX_ERS (50) failed attempts, `err` is raised; a full clean read-back raises `done`.
- R8: Flow 2 (lock) sets the bit chosen by `lock_sel` (0, 1 and 2 select commands 60H, 70H and 80H; 3 acts as 2). Each of its LOCK_N (10) pulses is that command, then D0H, then a `prog_n` pulse of LCK_W clocks. It performs no read after the signature.
- R9: `done` and `err` stay set until the next accepted start, which clears both. They are never high together. A start while `busy` is high, or with flow code 3, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| flow | input | 2 | 0 program, 1 chip erase, 2 lock bit, 3 ignored |
| lock_sel | input | 2 | Lock bit chosen for flow 2 |
| addr_lo | input | AW | First address of the range |
| addr_hi | input | AW | Last address of the range (not below addr_lo) |
| src_data | input | 8 | Byte to program at `tgt_addr` |
| tgt_addr | output | AW | Address bus to the device |
| tgt_dout | output | 8 | Command or data byte to the device |
| tgt_dout_en | output | 1 | Host drives the data bus |
| tgt_din | input | 8 | Data read from the device |
| cmd_n | output | 1 | Command strobe, active low |
| prog_n | output | 1 | Program strobe, active low |
| oe_n | output | 1 | Device read enable, active low |
| hv_sel | output | 1 | Select high programming voltage |
| busy | output | 1 | A flow is running |
| done | output | 1 | Last flow finished cleanly |
| err | output | 1 | Last flow hit its retry limit |

## Verification
The retry limit and the end of the address range can fall in the same read-back: the last byte of the range may match exactly on its tenth pulse. The bench sets up a device model whose final byte needs ten pulses. It expects `done` with no `err`, and exactly ten pulses on that byte. A neighbouring case, where a middle byte needs eleven pulses, must end in `err` with that byte pulsed ten times and the next one never pulsed.

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
module flash_prog_seq #(
  parameter int AW      = 13,
  parameter int SU      = 5,
  parameter int CMD_W   = 25,
  parameter int RD_W    = 25,
  parameter int PGM_W   = 50000,
  parameter int LCK_W   = 25,
  parameter int ERS_W   = 50000,
  parameter int MAX_PGM = 10,
  parameter int MAX_ERS = 50,
  parameter int LOCK_N  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    flow,
  input  logic [1:0]    lock_sel,
  input  logic [AW-1:0] addr_lo,
  input  logic [AW-1:0] addr_hi,
  input  logic [7:0]    src_data,
  output logic [AW-1:0] tgt_addr,
  output logic [7:0]    tgt_dout,
  output logic          tgt_dout_en,
  input  logic [7:0]    tgt_din,
  output logic          cmd_n,
  output logic          prog_n,
  output logic          oe_n,
  output logic          hv_sel,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int W1   = (PGM_W > ERS_W) ? PGM_W : ERS_W;
  localparam int W2   = (CMD_W > RD_W) ? CMD_W : RD_W;
  localparam int W3   = (LCK_W > SU) ? LCK_W : SU;
  localparam int WMX  = (W1 > W2) ? ((W1 > W3) ? W1 : W3) : ((W2 > W3) ? W2 : W3);
  localparam int TW   = $clog2(WMX + 1);
  localparam int PW   = $clog2(MAX_PGM + 1);
  localparam int EW   = $clog2(MAX_ERS + 1);
  localparam int LW   = $clog2(LOCK_N + 1);
  localparam logic [AW-1:0] SIG_ADDR = AW'(8'h32);

  typedef enum logic [3:0] {
    S_IDLE, S_SIGC, S_SIGR, S_PC, S_PP, S_VC, S_VR,
    S_LC, S_LD, S_LP, S_EC, S_ED, S_EP, S_AC, S_AR
  } st_t;
  typedef enum logic [1:0] {M_PRG = 2'd0, M_ERS = 2'd1, M_LCK = 2'd2} mode_t;

  st_t st;
  mode_t mode;
  logic [1:0]    ph;
  logic [TW-1:0] tm, wdt;
  logic [AW-1:0] lo, hi, addr;
  logic [1:0]    lk;
  logic [PW-1:0] tries;
  logic [EW-1:0] att;
  logic [LW-1:0] lpc;
  logic          rd_ok, hv12;
  logic [7:0]    wdat, exp_d;

  wire is_cmd = st inside {S_SIGC, S_PC, S_VC, S_LC, S_LD, S_EC, S_ED, S_AC};
  wire is_pls = st inside {S_PP, S_LP, S_EP};
  wire is_rd  = st inside {S_SIGR, S_VR, S_AR};
  wire act_end  = (ph == 2'd1) && (tm == wdt - 1'b1);
  wire step_end = (st != S_IDLE) && (ph == 2'd2) && (tm == TW'(SU - 1));

  assign busy        = (st != S_IDLE);
  assign cmd_n       = !(is_cmd && ph == 2'd1);
  assign prog_n      = !(is_pls && ph == 2'd1);
  assign oe_n        = !(is_rd && ph == 2'd1);
  assign tgt_dout_en = is_cmd || is_pls;
  assign hv_sel      = is_pls && hv12;
  assign tgt_addr    = (st == S_SIGR) ? SIG_ADDR : addr;
  assign wdat        = (mode == M_PRG) ? src_data : 8'h00;
  assign exp_d       = (st == S_AR) ? 8'hFF : wdat;

  always_comb begin
    case (st)
      S_PP:                wdt = TW'(PGM_W);
      S_LP:                wdt = TW'(LCK_W);
      S_EP:                wdt = TW'(ERS_W);
      S_SIGR, S_VR, S_AR:  wdt = TW'(RD_W);
      default:             wdt = TW'(CMD_W);
    endcase
    case (st)
      S_SIGC:              tgt_dout = 8'h90;
      S_PC:                tgt_dout = 8'h40;
      S_PP:                tgt_dout = wdat;
      S_VC:                tgt_dout = 8'hC0;
      S_LC:                tgt_dout = 8'h60 + {2'b00, lk, 4'h0};
      S_LD, S_LP, S_ED, S_EP: tgt_dout = 8'hD0;
      S_EC:                tgt_dout = 8'h20;
      S_AC:                tgt_dout = 8'hA0;
      default:             tgt_dout = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode <= M_PRG; ph <= 2'd0; tm <= '0;
      lo <= '0; hi <= '0; addr <= '0; lk <= 2'd0;
      tries <= '0; att <= '0; lpc <= '0;
      rd_ok <= 1'b0; hv12 <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else if (st == S_IDLE) begin
      ph <= 2'd0; tm <= '0;
      if (start && flow != 2'd3) begin
        mode  <= mode_t'(flow);
        lo    <= addr_lo; hi <= addr_hi; addr <= addr_lo;
        lk    <= (flow != 2'd2) ? 2'd0 : ((lock_sel == 2'd3) ? 2'd2 : lock_sel);
        tries <= '0; att <= '0; lpc <= '0;
        done  <= 1'b0; err <= 1'b0;
        st    <= S_SIGC;
      end
    end else begin
      if (ph == 2'd0) begin
        if (tm == TW'(SU - 1)) begin ph <= 2'd1; tm <= '0; end else tm <= tm + 1'b1;
      end else if (ph == 2'd1) begin
        if (act_end) begin ph <= 2'd2; tm <= '0; end else tm <= tm + 1'b1;
      end else begin
        if (step_end) begin ph <= 2'd0; tm <= '0; end else tm <= tm + 1'b1;
      end
      if (is_rd && act_end) begin
        rd_ok <= (tgt_din == exp_d);
        if (st == S_SIGR) hv12 <= (tgt_din == 8'hAA);
      end
      if (step_end) begin
        case (st)
          S_SIGC: st <= S_SIGR;
          S_SIGR: st <= (mode == M_LCK) ? S_LC : S_PC;
          S_PC:   st <= S_PP;
          S_PP:   begin tries <= tries + 1'b1; st <= S_VC; end
          S_VC:   st <= S_VR;
          S_VR:
            if (rd_ok) begin
              tries <= '0;
              if (addr != hi) begin addr <= addr + 1'b1; st <= S_PC; end
              else if (mode == M_PRG) begin done <= 1'b1; st <= S_IDLE; end
              else begin lk <= 2'd0; lpc <= '0; st <= S_LC; end
            end else if (tries == PW'(MAX_PGM)) begin
              err <= 1'b1; st <= S_IDLE;
            end else st <= S_PC;
          S_LC:   st <= S_LD;
          S_LD:   st <= S_LP;
          S_LP:
            if (lpc == LW'(LOCK_N - 1)) begin
              lpc <= '0;
              if (mode == M_LCK) begin done <= 1'b1; st <= S_IDLE; end
              else if (lk == 2'd2) begin att <= '0; st <= S_EC; end
              else begin lk <= lk + 1'b1; st <= S_LC; end
            end else begin lpc <= lpc + 1'b1; st <= S_LC; end
          S_EC:   st <= S_ED;
          S_ED:   st <= S_EP;
          S_EP:   begin att <= att + 1'b1; st <= S_AC; end
          S_AC:   begin addr <= lo; st <= S_AR; end
          S_AR:
            if (rd_ok) begin
              if (addr == hi) begin done <= 1'b1; st <= S_IDLE; end
              else addr <= addr + 1'b1;
            end else if (att == EW'(MAX_ERS)) begin
              err <= 1'b1; st <= S_IDLE;
            end else st <= S_EC;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_cmd_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_n && $past(!cmd_n)) |-> $stable(tgt_dout));
  p_no_contend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !tgt_dout_en);
  p_pulse_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (tgt_addr >= lo && tgt_addr <= hi));
  p_try_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= PW'(MAX_PGM));
  p_att_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    att <= EW'(MAX_ERS));
  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd_n && prog_n && oe_n && !hv_sel));
endmodule

// File: tb/sim_flash_prog_seq.sv
`timescale 1ns/1ps
module sim_flash_prog_seq;
  localparam int AW = 7, SU = 2, CMD_W = 3, RD_W = 2, PGM_W = 6, LCK_W = 4, ERS_W = 8;
  localparam int CLK = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] flow = 0, lock_sel = 0;
  logic [AW-1:0] addr_lo = 0, addr_hi = 0, tgt_addr;
  logic [7:0] src_data, tgt_dout, tgt_din;
  logic tgt_dout_en, cmd_n, prog_n, oe_n, hv_sel, busy, done, err;

  flash_prog_seq #(.AW(AW), .SU(SU), .CMD_W(CMD_W), .RD_W(RD_W), .PGM_W(PGM_W),
    .LCK_W(LCK_W), .ERS_W(ERS_W)) u0 (.*);

  always #2 clk = ~clk;

  logic [7:0] mem [128];
  logic [7:0] src_mem [128];
  int need [128];
  int pcnt [128];
  int lockcnt [3];
  int ecnt, eneed, elo, ehi, zero_ok, lock_before;
  logic [7:0] sig = 8'hAA, last_cmd = 8'h00, prev_cmd = 8'h00, pd;
  logic [AW-1:0] pa;
  longint t_dchg = 0, t_srise = -1000, t_fall = -1, p_fall = -1;
  int tviol = 0, cmd_seen = 0, hvbad = 0, hvseen = 0, oe_falls = 0, c70 = 0, cd0 = 0;
  int tests = 0, fails = 0, cyc = 0;

  assign src_data = src_mem[tgt_addr];
  always_comb begin
    if (!oe_n) tgt_din = (last_cmd == 8'h90 && tgt_addr == AW'(8'h32)) ? sig : mem[tgt_addr];
    else tgt_din = 8'hFF;
  end

  // device model and strobe timing monitors (R2)
  always @(tgt_dout or tgt_dout_en) begin
    if ($time - t_srise < SU*CLK) tviol++;
    t_dchg = $time;
  end
  always @(negedge cmd_n) begin
    cmd_seen++; t_fall = $time;
    if ($time - t_dchg < SU*CLK || !tgt_dout_en) tviol++;
  end
  always @(posedge cmd_n) if (t_fall >= 0) begin
    if ($time - t_fall != CMD_W*CLK) tviol++;
    t_srise = $time; prev_cmd = last_cmd; last_cmd = tgt_dout;
    if (tgt_dout == 8'h70) c70++;
    if (tgt_dout == 8'hD0) cd0++;
  end
  always @(negedge oe_n) oe_falls++;
  always @(negedge prog_n) begin
    p_fall = $time; pa = tgt_addr; pd = tgt_dout;
    if (hv_sel !== (sig == 8'hAA)) hvbad++;
    if (hv_sel) hvseen++;
    if ($time - t_dchg < SU*CLK || !tgt_dout_en) tviol++;
  end
  always @(posedge prog_n) if (p_fall >= 0) begin
    t_srise = $time;
    if (last_cmd == 8'h40) begin
      if ($time - p_fall != PGM_W*CLK) tviol++;
      pcnt[pa]++;
      if (pcnt[pa] >= need[pa]) mem[pa] = mem[pa] & pd;
    end else if (last_cmd == 8'hD0 && prev_cmd == 8'h20) begin
      if ($time - p_fall != ERS_W*CLK) tviol++;
      if (ecnt == 0) begin
        zero_ok = 1;
        for (int a = elo; a <= ehi; a++) if (mem[a] != 8'h00) zero_ok = 0;
        lock_before = (lockcnt[0] == 10 && lockcnt[1] == 10 && lockcnt[2] == 10);
      end
      ecnt++;
      if (ecnt >= eneed) for (int a = 0; a < 128; a++) mem[a] = 8'hFF;
    end else if (last_cmd == 8'hD0) begin
      if ($time - p_fall != LCK_W*CLK) tviol++;
      if (prev_cmd == 8'h60) lockcnt[0]++;
      else if (prev_cmd == 8'h70) lockcnt[1]++;
      else if (prev_cmd == 8'h80) lockcnt[2]++;
      else tviol++;
    end else tviol++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int exp_pulses(logic [7:0] d, int n);
    if (d == 8'hFF) return 1;
    return (n > 10) ? 10 : n;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int a = 0; a < 128; a++) begin
      mem[a] = 8'hFF; pcnt[a] = 0; need[a] = 1; src_mem[a] = 8'h00;
    end
    for (int i = 0; i < 3; i++) lockcnt[i] = 0;
    ecnt = 0; eneed = 1; zero_ok = 0; lock_before = 0; oe_falls = 0; c70 = 0; cd0 = 0;
  endtask

  task automatic kick(int f, int lo, int hi, int sel);
    @(negedge clk);
    flow = f[1:0]; addr_lo = AW'(lo); addr_hi = AW'(hi); lock_sel = sel[1:0]; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    int bad, lo, hi;
    void'($urandom(32'd1234));
    clear_model();
    repeat (3) @(negedge clk);
    chk("R1", "strobes high in reset", {cmd_n, prog_n, oe_n}, 3'b111);
    chk("R1", "flags low in reset", {tgt_dout_en, hv_sel, busy, done, err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", {cmd_n, prog_n, oe_n, busy, done, err}, 6'b111000);

    // random program runs (R4, R3)
    for (int it = 0; it < 3; it++) begin
      clear_model(); sig = 8'hAA;
      lo = $urandom_range(0, 100); hi = lo + $urandom_range(0, 10);
      for (int a = lo; a <= hi; a++) begin
        src_mem[a] = 8'($urandom); need[a] = $urandom_range(1, 4);
      end
      kick(0, lo, hi, 0); wait_idle();
      chk("R4", "program done", {done, err}, 2'b10);
      bad = 0;
      for (int a = lo; a <= hi; a++) begin
        if (mem[a] != src_mem[a]) bad++;
        if (pcnt[a] != exp_pulses(src_mem[a], need[a])) bad++;
      end
      chk("R4", "bytes and pulse counts", bad, 0);
      bad = 0;
      for (int a = 0; a < 128; a++) if ((a < lo || a > hi) && pcnt[a] != 0) bad++;
      chk("R4", "no pulses outside range", bad, 0);
      chk("R3", "one signature read per program flow", (oe_falls > hi - lo) ? 1 : 0, 1);
    end
    chk("R3", "high voltage seen with AAH signature", (hvseen > 0) ? 1 : 0, 1);

    // retry limit on a middle byte (R5)
    clear_model();
    for (int a = 10; a <= 13; a++) src_mem[a] = 8'h5A;
    need[11] = 11;
    kick(0, 10, 13, 0); wait_idle();
    chk("R5", "error flag on exhausted retries", {done, err}, 2'b01);
    chk("R5", "pulses on failing byte", pcnt[11], 10);
    chk("R5", "next byte untouched", pcnt[12], 0);
    chk("R5", "earlier byte written", mem[10], 8'h5A);

    // last byte succeeds on its tenth pulse (R5 with R4)
    clear_model();
    for (int a = 20; a <= 22; a++) src_mem[a] = 8'h0F;
    need[22] = 10;
    kick(0, 20, 22, 0); wait_idle();
    chk("R5", "tenth-pulse success on last byte", {done, err}, 2'b10);
    chk("R5", "pulses on last byte", pcnt[22], 10);

    // low voltage signature (R3)
    clear_model(); sig = 8'h55; hvseen = 0;
    src_mem[30] = 8'h12; src_mem[31] = 8'h34;
    kick(0, 30, 31, 0); wait_idle();
    chk("R3", "no high voltage with 55H signature", hvseen, 0);
    chk("R3", "program done with low voltage", {done, mem[31]}, {1'b1, 8'h34});
    sig = 8'hAA;

    // chip erase success (R6, R7)
    clear_model(); elo = 40; ehi = 47; eneed = 3;
    for (int a = 40; a <= 47; a++) mem[a] = 8'($urandom);
    kick(1, 40, 47, 0); wait_idle();
    chk("R7", "erase done", {done, err}, 2'b10);
    chk("R7", "erase attempts", ecnt, 3);
    chk("R6", "range zeroed before first erase", zero_ok, 1);
    chk("R6", "all lock bits set before erase", lock_before, 1);
    bad = 0;
    for (int a = 40; a <= 47; a++) if (mem[a] != 8'hFF) bad++;
    chk("R7", "range reads FFH", bad, 0);

    // chip erase never clears (R7)
    clear_model(); elo = 50; ehi = 53; eneed = 1000;
    kick(1, 50, 53, 0); wait_idle();
    chk("R7", "erase error flag", {done, err}, 2'b01);
    chk("R7", "erase attempt limit", ecnt, 50);

    // lock flow (R8)
    clear_model();
    kick(2, 0, 0, 1); wait_idle();
    chk("R8", "lock done", {done, err}, 2'b10);
    chk("R8", "lock pulses per bit", lockcnt[0] * 10000 + lockcnt[1] * 100 + lockcnt[2], 1000);
    chk("R8", "only signature read", oe_falls, 1);
    chk("R8", "70H command count", c70, 10);
    chk("R8", "D0H command count", cd0, 10);

    // new start clears flags, second start while busy is ignored (R9)
    clear_model();
    for (int a = 60; a <= 63; a++) src_mem[a] = 8'hA5;
    kick(0, 60, 63, 0);
    chk("R9", "flags cleared on start", {busy, done, err}, 3'b100);
    repeat (10) @(negedge clk);
    kick(2, 0, 0, 0); wait_idle();
    chk("R9", "start while busy ignored", lockcnt[0], 0);
    chk("R9", "busy program still completes", {done, mem[63]}, {1'b1, 8'hA5});
    kick(3, 0, 0, 0);
    repeat (5) @(negedge clk);
    chk("R9", "flow 3 ignored", {busy, done}, 2'b01);

    chk("R2", "strobe timing violations", tviol, 0);
    chk("R2", "commands observed", (cmd_seen > 100) ? 1 : 0, 1);
    chk("R3", "voltage select mismatches at pulses", hvbad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule